// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block turns the serial NRZ bit stream of a 10 Mb/s MAC-side transmit path into Manchester-coded line symbols. It runs from a clock at twice the bit rate, so one clock tick is one half of a bit cell (20 MHz for 100 ns bits). A frame begins when the transmit request is seen high while the link is reported good. It continues one bit cell at a time for as long as both stay high at each cell boundary. It ends cleanly at the next cell boundary after either one drops.

Each bit cell carries the complement of the bit in its first half and the bit itself in its second half. A one is therefore a rising edge at mid-cell and a zero is a falling edge. The idle line level is high, which is the level of the second half of a one. A frame whose last bit is a one has its last edge at the centre of that cell. A frame whose last bit is a zero has one more edge, back to idle, at the closing cell boundary. Preamble generation, link pulses, filtering and the analog driver are handled elsewhere.

Top module: `manchester_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, line_out is high (idle) and tx_active is low.
- R2: When idle, a clock edge that samples tx_en and link_ok both high starts a frame. tx_active is high after that edge, and line_out shows the first half of the bit tx_data carried at that edge.
- R3: Every bit cell lasts two ticks. line_out is the complement of the bit for the first tick and the bit for the second tick, so a 1 rises at mid-cell, a 0 falls at mid-cell, and every cell has a mid-cell edge.
- R4: tx_en and link_ok are sampled only at cell boundaries. A frame holds exactly one cell for each boundary at which both were high, and the decoded bits equal the tx_data values sampled at those boundaries, in order.
- R5: At a cell boundary where tx_en is low, the frame ends. tx_active goes low and line_out is high (idle) from that edge on.
- R6: When the last bit is 1, line_out does not change at the closing boundary. The final edge is the one at mid-cell.
- R7: When the last bit is 0, line_out rises from low to high at the closing boundary. The final edge is at the boundary.
- R8: link_ok low at a cell boundary ends the frame as in R5, even with tx_en high. link_ok low while idle prevents a start. link_ok low only inside a cell has no effect.
- R9: Changes on tx_data between cell boundaries have no effect on line_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock, one tick per half cell |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit request from the MAC side |
| tx_data | input | 1 | NRZ data bit, sampled at each cell boundary |
| link_ok | input | 1 | Link reported good; required to start and continue |
| line_out | output | 1 | Manchester-coded line level, high when idle |
| tx_active | output | 1 | High while a frame is being coded |

## Verification
The assertions assume a clock ratio of one tick per half cell and a reset held over at least one edge. They also assume that tx_en, link_ok and tx_data are driven only between edges, so each edge sees a settled value. The bench drives all inputs on the falling clock edge and meets these conditions. Within those limits it sweeps every bit pattern for frame lengths of one to six bits, ending alternate frames by dropping tx_en or by dropping link_ok. It also toggles tx_data in every first half cell and pulses link_ok low inside cells, to show that only boundary samples count.

// File: rtl/mtx_pkg.sv
// Package mtx_pkg
// Purpose : shared types and helpers for the Manchester transmit encoder.
// Assumes : nothing beyond IEEE 1800-2017 synthesizable constructs.
package mtx_pkg;

    // Which half of the current bit cell is on the line.
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    // Line level of the half cell that carries the bit itself.
    function automatic logic bit_half_level(input logic ones_rise, input logic b);
        return ones_rise ? b : ~b;
    endfunction

endpackage

// File: rtl/mtx_gate.sv
// Module  : mtx_gate
// Purpose : frame sequencing. It decides when a frame starts, steps the half
//           cells, and ends the frame at a cell boundary once tx_en or
//           link_ok is low.
// Assumes : TICKS_PER_HALF clock ticks per half cell; inputs settle between
//           edges; synchronous active-low reset.
module mtx_gate
    import mtx_pkg::*;
#(
    parameter int TICKS_PER_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic link_ok,
    output logic active,
    output logic load,
    output logic mid,
    output logic finish
);
    localparam int CW = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_HALF - 1);

    logic [CW-1:0] tick_q;
    half_e         half_q;
    logic          active_q;
    logic          tick_end;
    logic          boundary;
    logic          go;

    // Decode the half-cell end, the cell boundary and the continue condition.
    always_comb begin
        tick_end = (tick_q == LAST_TICK);
        boundary = active_q && (half_q == HALF_SECOND) && tick_end;
        go       = tx_en && link_ok;
        load     = (!active_q && go) || (boundary && go);
        mid      = active_q && (half_q == HALF_FIRST) && tick_end;
        finish   = boundary && !go;
    end

    // Track frame activity, the half-cell phase and the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            half_q   <= HALF_FIRST;
            tick_q   <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            half_q   <= HALF_FIRST;
            tick_q   <= '0;
        end else if (finish) begin
            active_q <= 1'b0;
            half_q   <= HALF_FIRST;
            tick_q   <= '0;
        end else if (active_q) begin
            if (tick_end) begin
                tick_q <= '0;
                half_q <= HALF_SECOND;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign active = active_q;

    AST_NO_START_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !link_ok) |=> !active_q); // R8

    AST_HOLD_TO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !boundary) |=> active_q); // R4

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load, mid, finish}) <= 1); // R3

endmodule

// File: rtl/mtx_symbol.sv
// Module  : mtx_symbol
// Purpose : holds the bit of the current cell and drives the line level for
//           each half cell. It returns the line to idle when a frame ends.
// Assumes : load, mid and finish are mutually exclusive single-cycle strobes
//           from mtx_gate; synchronous active-low reset.
module mtx_symbol
    import mtx_pkg::*;
#(
    parameter bit ONE_RISES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic mid,
    input  logic finish,
    input  logic data_in,
    output logic line_q
);
    localparam logic IDLE_LVL = bit_half_level(ONE_RISES, 1'b1);

    logic bit_q;
    logic first_lvl;
    logic second_lvl;

    generate
        if (ONE_RISES) begin : g_one_rises
            // A one is low then high.
            assign first_lvl  = ~data_in;
            assign second_lvl = bit_q;
        end else begin : g_one_falls
            // A one is high then low.
            assign first_lvl  = data_in;
            assign second_lvl = ~bit_q;
        end
    endgenerate

    // Latch the cell bit and step the line level on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= 1'b0;
            line_q <= IDLE_LVL;
        end else if (load) begin
            bit_q  <= data_in;
            line_q <= first_lvl;
        end else if (mid) begin
            line_q <= second_lvl;
        end else if (finish) begin
            line_q <= IDLE_LVL;
        end
    end

    AST_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        mid |=> (line_q != $past(line_q))); // R3

    AST_HOLD_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !mid && !finish) |=> $stable(line_q)); // R9

endmodule

// File: rtl/manchester_tx.sv
// Module  : manchester_tx
// Purpose : top level of the Manchester transmit encoder. It joins frame
//           sequencing (mtx_gate) with the line level driver (mtx_symbol).
// Assumes : clock at twice the bit rate by default (TICKS_PER_HALF = 1);
//           synchronous active-low reset; idle line level equals the
//           second-half level of a one.
module manchester_tx
    import mtx_pkg::*;
#(
    parameter int TICKS_PER_HALF = 1,
    parameter bit ONE_RISES      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_data,
    input  logic link_ok,
    output logic line_out,
    output logic tx_active
);
    localparam logic IDLE_LVL = bit_half_level(ONE_RISES, 1'b1);

    logic load_s;
    logic mid_s;
    logic finish_s;

    mtx_gate #(
        .TICKS_PER_HALF(TICKS_PER_HALF)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .link_ok(link_ok),
        .active (tx_active),
        .load   (load_s),
        .mid    (mid_s),
        .finish (finish_s)
    );

    mtx_symbol #(
        .ONE_RISES(ONE_RISES)
    ) u_symbol (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_s),
        .mid    (mid_s),
        .finish (finish_s),
        .data_in(tx_data),
        .line_q (line_out)
    );

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (line_out == IDLE_LVL)); // R5

    AST_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> (line_out == bit_half_level(ONE_RISES, !$past(tx_data)))); // R2

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> (line_out == IDLE_LVL)); // R7

endmodule

// File: tb/manchester_tx_test.sv
module manchester_tx_test;
    logic clk     = 1'b0;
    logic rst_n   = 1'b0;
    logic tx_en   = 1'b0;
    logic tx_data = 1'b0;
    logic link_ok = 1'b0;
    logic line_out;
    logic tx_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    manchester_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
        .link_ok(link_ok), .line_out(line_out), .tx_active(tx_active)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
        end
    end

    // One frame of len bits, LSB first; end via link_ok drop when link_end.
    task automatic send_frame(int len, int pat, bit link_end);
        logic second;
        int   decoded = 0;
        @(negedge clk);
        tx_en   = 1'b1;
        link_ok = 1'b1;
        tx_data = pat[0];
        second  = 1'b1;
        for (int i = 0; i < len; i++) begin
            logic b;
            b = pat[i];
            @(negedge clk);
            check_eq("R2 tx_active in cell", tx_active, 1);
            check_eq("R3 first half is complement", line_out, !b);
            tx_data = !b;                 // R9 disturbance inside the cell
            if (i % 2 == 1) link_ok = 1'b0; // R8 glitch inside the cell
            @(negedge clk);
            check_eq("R3 second half is bit", line_out, b);
            if (line_out) decoded |= (1 << i);
            second  = line_out;
            link_ok = 1'b1;
            if (i == len - 1) begin
                if (link_end) link_ok = 1'b0;
                else          tx_en   = 1'b0;
            end else begin
                tx_data = pat[i + 1];
            end
        end
        @(negedge clk);
        check_eq(link_end ? "R8 link drop ends frame" : "R5 frame ended", tx_active, 0);
        check_eq("R5 idle high after end", line_out, 1);
        if (second) check_eq("R6 no edge at boundary after 1", line_out != second, 0);
        else        check_eq("R7 edge at boundary after 0", line_out != second, 1);
        check_eq("R4 decoded bits", decoded, pat & ((1 << len) - 1));
        tx_en   = 1'b0;
        link_ok = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 reset line idle", line_out, 1);
        check_eq("R1 reset inactive", tx_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 after reset line idle", line_out, 1);
        check_eq("R1 after reset inactive", tx_active, 0);

        // R8: no start while link is down
        tx_en = 1'b1;
        link_ok = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tx_data = k[0];
            @(negedge clk);
            check_eq("R8 no start offline", tx_active, 0);
            check_eq("R8 line idle offline", line_out, 1);
        end
        tx_en = 1'b0;
        link_ok = 1'b1;

        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                send_frame(len, pat, ((pat + len) % 2) == 1);
                @(negedge clk);
                check_eq("R5 stays idle", tx_active, 0);
            end
        end

        done = 1'b1;
        summary();
    end
endmodule